// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block sits between two 8-bit buses, called port A and port B. It keeps two separate stores, one for data moving from A to B and one for data moving from B to A. Each direction has three active-low controls: a chip enable, a latch enable and an output enable. While both the chip enable and the latch enable of a direction are low, that direction's store tracks its source port. When the latch enable goes high, the store freezes. The destination port is driven from the store only while the chip enable and the output enable are both low.

The design uses a free-running clock. The controls and the source data are sampled on every rising edge, and a transparent store takes a new sample on each edge, so the value it keeps is the last sample taken while it was transparent. A chip does not model a tristate pin as one wire, so each port is split into three signals: a data input, a data output and a drive-enable output. An undriven port shows zero on its data output. Reset is active low and asynchronous, and it clears both stores to zero.

Top module: `xcvr_latched_bidir`

## Requirements
- R1: While `rst_n` is low, both stores are cleared to zero. After `rst_n` is released, a path whose chip enable and output enable are low and whose latch enable is high shows zero on its destination data output.
- R2: On any clock edge where a path's chip enable is high, that path's store keeps its value, whatever its latch enable and source data are.
- R3: While a path's chip enable is high, its destination drive-enable is 0 and its destination data output is zero, whatever its output enable is.
- R4: On a clock edge where a path's chip enable and latch enable are both low, the store loads the source port data sampled at that edge.
- R5: Once the latch enable rises while the chip enable is low, later changes on the source port leave the store unchanged until the latch enable goes low again.
- R6: A destination drive-enable is 1 exactly when its path's chip enable and output enable are both low, in the same cycle as those inputs. The destination data output then equals the store.
- R7: While the chip enable is low and the output enable is high, the destination is undriven (drive-enable 0, data 0), but the store still loads as R4 describes.
- R8: The B-to-A path follows R2 to R7 using `ba_ce_n`, `ba_le_n` and `ba_oe_n`. It takes its source from `b_din` and drives `a_dout` and `a_drive`.
- R9: The controls and data of one path never change the store, the drive-enable or the data output of the other path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_din | input | 8 | Data arriving on port A (source for A-to-B) |
| a_dout | output | 8 | Data presented on port A from the B-to-A store |
| a_drive | output | 1 | Port A drive-enable (stands in for the tristate buffer) |
| b_din | input | 8 | Data arriving on port B (source for B-to-A) |
| b_dout | output | 8 | Data presented on port B from the A-to-B store |
| b_drive | output | 1 | Port B drive-enable |
| ab_ce_n | input | 1 | A-to-B chip enable, active low |
| ab_le_n | input | 1 | A-to-B latch enable, active low |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_ce_n | input | 1 | B-to-A chip enable, active low |
| ba_le_n | input | 1 | B-to-A latch enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |

## Verification
Drive-enables react in the same cycle as the chip enable and output enable, because the output gating is purely combinational. A load shows up on the destination data output one clock edge after the edge that sampled it. The bench drives every input on the falling edge. One time unit later it compares both drive-enables and both data outputs against a reference store that it advanced at the previous rising edge. At that rising edge it updates the reference from the inputs it drove, so every comparison falls inside the half-cycle after the outputs have settled. Random traffic on both paths is checked against one reference per path, which also covers the isolation between the two paths.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  localparam int NUM_PATHS = 2;
  localparam int PATH_AB   = 0;
  localparam int PATH_BA   = 1;

  // Active-low control triple for one direction
  typedef struct packed {
    logic ce_n;
    logic le_n;
    logic oe_n;
  } path_ctrl_t;

  // Store takes its source on this edge
  function automatic logic path_loads(path_ctrl_t c);
    return (c.ce_n == 1'b0) && (c.le_n == 1'b0);
  endfunction

  // Destination buffer is active
  function automatic logic path_drives(path_ctrl_t c);
    return (c.ce_n == 1'b0) && (c.oe_n == 1'b0);
  endfunction

  // Latch enable rose while the path is selected
  function automatic logic path_freezes(path_ctrl_t c, logic le_prev);
    return (c.ce_n == 1'b0) && c.le_n && !le_prev;
  endfunction

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  path_ctrl_t   ctrl,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         load_evt,
  output logic         freeze_evt
);

  logic le_prev;

  assign load_evt   = path_loads(ctrl);
  assign freeze_evt = path_freezes(ctrl, le_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q       <= '0;
      le_prev <= 1'b1;
    end else begin
      le_prev <= ctrl.le_n;
      if (load_evt) q <= din;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (q == '0));

  assert_ce_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.ce_n |=> (q == $past(q)));

  assert_transparent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (q == $past(din)));

  assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_evt |=> $stable(q));

endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  path_ctrl_t   ctrl,
  input  logic [W-1:0] q,
  output logic [W-1:0] dout,
  output logic         drive_en
);

  always_comb begin
    drive_en = path_drives(ctrl);
    dout     = drive_en ? q : '0;
  end

  assert_ce_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.ce_n |-> (!drive_en && dout == '0));

  assert_drive_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> (dout == q));

  assert_oe_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.ce_n && ctrl.oe_n) |-> (!drive_en && dout == '0));

endmodule

// File: rtl/xcvr_latched_bidir.sv
module xcvr_latched_bidir
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_din,
  output logic [W-1:0] a_dout,
  output logic         a_drive,
  input  logic [W-1:0] b_din,
  output logic [W-1:0] b_dout,
  output logic         b_drive,
  input  logic         ab_ce_n,
  input  logic         ab_le_n,
  input  logic         ab_oe_n,
  input  logic         ba_ce_n,
  input  logic         ba_le_n,
  input  logic         ba_oe_n
);

  path_ctrl_t ctrl   [NUM_PATHS];
  logic [W-1:0] src  [NUM_PATHS];
  logic [W-1:0] q    [NUM_PATHS];
  logic [W-1:0] dst  [NUM_PATHS];
  logic         drv  [NUM_PATHS];
  logic         load_evt   [NUM_PATHS];
  logic         freeze_evt [NUM_PATHS];

  assign ctrl[PATH_AB] = '{ce_n: ab_ce_n, le_n: ab_le_n, oe_n: ab_oe_n};
  assign ctrl[PATH_BA] = '{ce_n: ba_ce_n, le_n: ba_le_n, oe_n: ba_oe_n};
  assign src[PATH_AB]  = a_din;
  assign src[PATH_BA]  = b_din;

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    xcvr_store #(.W(W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl       (ctrl[p]),
      .din        (src[p]),
      .q          (q[p]),
      .load_evt   (load_evt[p]),
      .freeze_evt (freeze_evt[p])
    );
    xcvr_drive #(.W(W)) u_drive (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl     (ctrl[p]),
      .q        (q[p]),
      .dout     (dst[p]),
      .drive_en (drv[p])
    );
  end

  assign b_dout  = dst[PATH_AB];
  assign b_drive = drv[PATH_AB];
  assign a_dout  = dst[PATH_BA];
  assign a_drive = drv[PATH_BA];

  // Reverse path picks up port B data
  assert_ba_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt[PATH_BA] |=> (q[PATH_BA] == $past(b_din)));

  // A-to-B controls idle: its store cannot move, whatever B-to-A does
  assert_isolation_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_ce_n && !ba_ce_n) |=> $stable(q[PATH_AB]));

endmodule

// File: tb/tb_xcvr_latched_bidir.sv
module tb_xcvr_latched_bidir;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_din = '0, b_din = '0;
  logic [W-1:0] a_dout, b_dout;
  logic a_drive, b_drive;
  logic ab_ce_n = 1, ab_le_n = 1, ab_oe_n = 1;
  logic ba_ce_n = 1, ba_le_n = 1, ba_oe_n = 1;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] ref_ab = '0, ref_ba = '0;

  always #2 clk = ~clk;

  xcvr_latched_bidir #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .a_din(a_din), .a_dout(a_dout), .a_drive(a_drive),
    .b_din(b_din), .b_dout(b_dout), .b_drive(b_drive),
    .ab_ce_n(ab_ce_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_ce_n(ba_ce_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n)
  );

  function automatic logic exp_drive(logic ce_n, logic oe_n);
    return !(ce_n | oe_n);
  endfunction

  function automatic logic [W-1:0] exp_data(logic ce_n, logic oe_n, logic [W-1:0] st);
    return exp_drive(ce_n, oe_n) ? st : {W{1'b0}};
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare all outputs against the reference, tagging by control state
  task automatic check_outputs(string ctx);
    string tab, tba;
    tab = ab_ce_n ? "R3" : (ab_oe_n ? "R7" : "R6");
    tba = ba_ce_n ? "R8_R3" : (ba_oe_n ? "R8_R7" : "R8_R6");
    chk({tab, " b_drive ", ctx}, {{(W-1){1'b0}}, b_drive}, {{(W-1){1'b0}}, exp_drive(ab_ce_n, ab_oe_n)});
    chk({tab, " b_dout ", ctx}, b_dout, exp_data(ab_ce_n, ab_oe_n, ref_ab));
    chk({tba, " a_drive ", ctx}, {{(W-1){1'b0}}, a_drive}, {{(W-1){1'b0}}, exp_drive(ba_ce_n, ba_oe_n)});
    chk({tba, " a_dout ", ctx}, a_dout, exp_data(ba_ce_n, ba_oe_n, ref_ba));
  endtask

  // drive at falling edge, check, then advance the reference at rising edge
  task automatic step(string ctx);
    @(negedge clk);
    #1;
    check_outputs(ctx);
    @(posedge clk);
    if (!ab_ce_n && !ab_le_n) ref_ab = a_din;
    if (!ba_ce_n && !ba_le_n) ref_ba = b_din;
  endtask

  task automatic set_ab(logic ce, logic le, logic oe);
    ab_ce_n = ce; ab_le_n = le; ab_oe_n = oe;
  endtask

  task automatic set_ba(logic ce, logic le, logic oe);
    ba_ce_n = ce; ba_le_n = le; ba_oe_n = oe;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: read both stores with load blocked, expect zeros
    @(negedge clk);
    set_ab(0, 1, 0); set_ba(0, 1, 0);
    a_din = 8'hA5; b_din = 8'h5A;
    #1;
    chk("R1 b_dout after reset", b_dout, 8'h00);
    chk("R1 a_dout after reset", a_dout, 8'h00);
    @(posedge clk);

    // R4: transparent load, visible one edge later
    @(negedge clk); set_ab(0, 0, 0); a_din = 8'h3C;
    @(posedge clk); ref_ab = 8'h3C;
    @(negedge clk); a_din = 8'h3D; #1;
    chk("R4 b_dout shows loaded value", b_dout, 8'h3C);
    @(posedge clk); ref_ab = 8'h3D;
    // R5: freeze, then change A
    @(negedge clk); set_ab(0, 1, 0); a_din = 8'hFF;
    @(posedge clk);
    @(negedge clk); a_din = 8'h11; #1;
    chk("R5 frozen after le rise", b_dout, 8'h3D);
    @(posedge clk);
    // R7: oe high, still loads
    @(negedge clk); set_ab(0, 0, 1); a_din = 8'h77; #1;
    chk("R7 b_drive low with oe high", {7'b0, b_drive}, 8'h00);
    @(posedge clk); ref_ab = 8'h77;
    @(negedge clk); set_ab(0, 1, 0); #1;
    chk("R7 load happened while undriven", b_dout, 8'h77);
    @(posedge clk);
    // R2/R3: ce high blocks load and drive
    @(negedge clk); set_ab(1, 0, 0); a_din = 8'h99; #1;
    chk("R3 b_drive low with ce high", {7'b0, b_drive}, 8'h00);
    chk("R3 b_dout zero with ce high", b_dout, 8'h00);
    @(posedge clk);
    @(negedge clk); set_ab(0, 1, 0); #1;
    chk("R2 store held under ce high", b_dout, 8'h77);
    @(posedge clk);
    // R8 and R9: load B-to-A while A-to-B is frozen and driven
    @(negedge clk); set_ba(0, 0, 0); b_din = 8'hC3; a_din = 8'h01;
    @(posedge clk); ref_ba = 8'hC3;
    @(negedge clk); set_ba(0, 1, 0); #1;
    chk("R8 a_dout shows B-to-A load", a_dout, 8'hC3);
    chk("R9 A-to-B unaffected", b_dout, 8'h77);
    chk("R9 b_drive unaffected", {7'b0, b_drive}, 8'h01);
    @(posedge clk);

    // constrained random traffic against the reference
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      a_din = W'($urandom);
      b_din = W'($urandom);
      set_ab(($urandom % 4) == 0, ($urandom % 3) != 0, ($urandom % 4) == 0);
      set_ba(($urandom % 4) == 0, ($urandom % 3) != 0, ($urandom % 4) == 0);
      #1;
      check_outputs("R9 random");
      @(posedge clk);
      if (!ab_ce_n && !ab_le_n) ref_ab = a_din;
      if (!ba_ce_n && !ba_le_n) ref_ba = b_din;
    end
    step("R6 final");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule